// File: doc/BRIEF.md
# Banked Register Space Address Translator

This block maps every access to an 8-bit register space of 256 byte locations onto its physical target. A requester presents an address together with an access mode. In the working mode only the low four address bits count: the upper four bits come from the high nibble of a pointer byte held inside the block, which picks one of sixteen 16-byte groups. In the direct and indirect modes the full 8-bit address is used.

The low nibble of the same pointer byte picks which expansion bank is overlaid on locations 00h–0Fh. Bank 0 leaves the main RAM visible there. Banks D and F route the access to two external 16-register windows. Every other bank value makes that range unimplemented. The 16 locations E0h–EFh cannot be reached by a direct address; the working and indirect modes reach them. The top 16 locations hold control registers: the pointer itself lives at FDh, F0h–F5h are reserved, and the rest are plain storage.

Any access that lands on an unimplemented or reserved location reads FFh and its writes are dropped. Reads are combinational. Writes take effect on the rising clock edge.

Top module: `bank_reg_map`

## Requirements
- R1: After reset the pointer byte reads 00h and every RAM location reads 00h.
- R2: acc_mode 01 (working) forms the effective address from pointer bits 7–4 as its upper nibble and acc_addr bits 3–0 as its lower nibble; acc_addr bits 7–4 have no effect.
- R3: acc_mode 00 (direct), 10 and 11 (indirect) use acc_addr unchanged as the effective address, and phys_addr always shows the effective address.
- R4: With pointer bits 3–0 equal to 0h, effective addresses 00h–0Fh reach the main RAM.
- R5: With pointer bits 3–0 equal to Dh, effective addresses 00h–0Fh assert win_d_sel, present the low nibble on win_idx, return win_d_rdata, and pulse win_we when wr_en is high; the RAM is not written.
- R6: With pointer bits 3–0 equal to Fh, the same holds for window F using win_f_sel and win_f_rdata.
- R7: With any other value in pointer bits 3–0, effective addresses 00h–0Fh read FFh, and writes leave the RAM underneath unchanged.
- R8: A direct access to E0h–EFh reads FFh and its write is dropped; working and indirect accesses reach the RAM there.
- R9: Effective addresses F0h–F5h are reserved: they read FFh and ignore writes.
- R10: Effective address FDh, in any mode, reads the pointer byte; a write there loads the pointer at the next rising edge, and the pointer changes at no other time.
- R11: rd_data follows the address in the same cycle; a write with wr_en high updates the RAM at the rising edge, and the written value reads back afterwards.
- R12: tgt_kind reports the target: 0 RAM, 1 window D, 2 window F, 3 pointer, 4 unimplemented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| acc_mode | input | 2 | 00 direct, 01 working, 10/11 indirect |
| acc_addr | input | 8 | Requested address (low nibble only in working mode) |
| wr_en | input | 1 | Write strobe for the current access |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for the current access |
| tgt_kind | output | 3 | Decoded target class |
| phys_addr | output | 8 | Effective 8-bit address |
| rp_value | output | 8 | Current pointer byte |
| win_d_sel | output | 1 | Window D selected |
| win_f_sel | output | 1 | Window F selected |
| win_idx | output | 4 | Register index inside the selected window |
| win_we | output | 1 | Write strobe toward the selected window |
| win_d_rdata | input | 8 | Read data from window D |
| win_f_rdata | input | 8 | Read data from window F |

## Verification
The properties watch the structural rules on every cycle. The pointer loads only on a write to FDh and holds otherwise. Working-mode addresses always carry the pointer's upper nibble. Direct access to E0h–EFh and unimplemented banks always report an unimplemented target that reads FFh. At most one window is selected, and it receives a write strobe only with wr_en. Data integrity needs the bench scenarios, because it spans several accesses: a dropped write leaves the old RAM byte, a location written through one mode is read back through another, and a pointer written through a working address redirects the very next access.

// File: rtl/bank_reg_map_pkg.sv
// Shared encodings for the banked register space translator.
// Assumes an 8-bit address space split into 16-byte groups.
package bank_reg_map_pkg;

    typedef enum logic [1:0] {
        AM_DIRECT   = 2'b00,
        AM_WORKING  = 2'b01,
        AM_INDIRECT = 2'b10,
        AM_IND_ALT  = 2'b11
    } acc_mode_e;

    typedef enum logic [2:0] {
        TK_RAM   = 3'd0,
        TK_WIN_D = 3'd1,
        TK_WIN_F = 3'd2,
        TK_PTR   = 3'd3,
        TK_NONE  = 3'd4
    } tgt_kind_e;

endpackage

// File: rtl/rp_pointer_reg.sv
// Pointer byte holding the working-group nibble (upper) and the
// expansion-bank nibble (lower). Assumes the caller qualifies the load.
module rp_pointer_reg #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] q
);

    // Load the pointer on request, clear it on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (load) begin
            q <= din;
        end
    end

endmodule

// File: rtl/rp_addr_decode.sv
// Combinational address translation: forms the effective address from
// the access mode and the pointer, then classifies the target.
// Assumes AW is even so the address splits into two equal nibbles.
module rp_addr_decode
    import bank_reg_map_pkg::*;
#(
    parameter int            AW          = 8,
    parameter logic [AW/2-1:0] BANK_D_ID = 4'hD,
    parameter logic [AW/2-1:0] BANK_F_ID = 4'hF,
    parameter logic [AW/2-1:0] SHADOW_GRP = 4'hE,
    parameter logic [AW-1:0] PTR_ADDR    = 8'hFD,
    parameter logic [AW-1:0] RSVD_FIRST  = 8'hF0,
    parameter logic [AW-1:0] RSVD_LAST   = 8'hF5
) (
    input  logic [1:0]    acc_mode,
    input  logic [AW-1:0] acc_addr,
    input  logic [AW-1:0] rp,
    output logic [AW-1:0] eff_addr,
    output tgt_kind_e     kind
);

    localparam int NW = AW / 2;

    logic [NW-1:0] grp;
    logic [NW-1:0] bank;
    logic          is_direct;

    // Form the effective address from the access mode.
    always_comb begin
        if (acc_mode == AM_WORKING) begin
            eff_addr = {rp[AW-1:NW], acc_addr[NW-1:0]};
        end else begin
            eff_addr = acc_addr;
        end
    end

    assign grp       = eff_addr[AW-1:NW];
    assign bank      = rp[NW-1:0];
    assign is_direct = (acc_mode == AM_DIRECT);

    // Classify the effective address into a target, highest priority first.
    always_comb begin
        kind = TK_RAM;
        if (is_direct && (grp == SHADOW_GRP)) begin
            kind = TK_NONE;
        end else if (eff_addr == PTR_ADDR) begin
            kind = TK_PTR;
        end else if ((eff_addr >= RSVD_FIRST) && (eff_addr <= RSVD_LAST)) begin
            kind = TK_NONE;
        end else if (grp == '0) begin
            if (bank == '0) begin
                kind = TK_RAM;
            end else if (bank == BANK_D_ID) begin
                kind = TK_WIN_D;
            end else if (bank == BANK_F_ID) begin
                kind = TK_WIN_F;
            end else begin
                kind = TK_NONE;
            end
        end
    end

endmodule

// File: rtl/rp_ram_store.sv
// Byte storage for the main register RAM: combinational read, write on
// the rising edge. CLEAR_ON_RST picks whether reset clears the contents.
module rp_ram_store #(
    parameter int AW           = 8,
    parameter int DW           = 8,
    parameter bit CLEAR_ON_RST = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    generate
        if (CLEAR_ON_RST) begin : g_clear
            // Clear every byte on reset, otherwise accept a write.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    for (int i = 0; i < DEPTH; i++) begin
                        mem[i] <= '0;
                    end
                end else if (we) begin
                    mem[addr] <= wdata;
                end
            end
        end else begin : g_keep
            // Accept a write; contents survive reset.
            always_ff @(posedge clk) begin
                if (rst_n && we) begin
                    mem[addr] <= wdata;
                end
            end
        end
    endgenerate

    assign rdata = mem[addr];

endmodule

// File: rtl/bank_reg_map.sv
// Top of the banked register space translator. Decodes each access,
// steers writes to the RAM, the pointer or an expansion window, and
// multiplexes read data. Unimplemented targets read all ones.
module bank_reg_map
    import bank_reg_map_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    acc_mode,
    input  logic [AW-1:0] acc_addr,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] rd_data,
    output logic [2:0]    tgt_kind,
    output logic [AW-1:0] phys_addr,
    output logic [DW-1:0] rp_value,
    output logic          win_d_sel,
    output logic          win_f_sel,
    output logic [AW/2-1:0] win_idx,
    output logic          win_we,
    input  logic [DW-1:0] win_d_rdata,
    input  logic [DW-1:0] win_f_rdata
);

    localparam int NW = AW / 2;

    logic [AW-1:0] eff_addr;
    tgt_kind_e     kind;
    logic [DW-1:0] rp_q;
    logic [DW-1:0] ram_rdata;
    logic          ram_we;
    logic          ptr_we;

    rp_addr_decode #(.AW(AW)) u_dec (
        .acc_mode (acc_mode),
        .acc_addr (acc_addr),
        .rp       (rp_q),
        .eff_addr (eff_addr),
        .kind     (kind)
    );

    rp_pointer_reg #(.DW(DW)) u_ptr (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (ptr_we),
        .din   (wr_data),
        .q     (rp_q)
    );

    rp_ram_store #(.AW(AW), .DW(DW), .CLEAR_ON_RST(1'b1)) u_ram (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (ram_we),
        .addr  (eff_addr),
        .wdata (wr_data),
        .rdata (ram_rdata)
    );

    assign ram_we    = wr_en && (kind == TK_RAM);
    assign ptr_we    = wr_en && (kind == TK_PTR);
    assign win_d_sel = (kind == TK_WIN_D);
    assign win_f_sel = (kind == TK_WIN_F);
    assign win_idx   = eff_addr[NW-1:0];
    assign win_we    = wr_en && (win_d_sel || win_f_sel);
    assign tgt_kind  = kind;
    assign phys_addr = eff_addr;
    assign rp_value  = rp_q;

    // Select read data from the decoded target.
    always_comb begin
        case (kind)
            TK_RAM:   rd_data = ram_rdata;
            TK_WIN_D: rd_data = win_d_rdata;
            TK_WIN_F: rd_data = win_f_rdata;
            TK_PTR:   rd_data = rp_q;
            default:  rd_data = '1;
        endcase
    end

endmodule

// File: rtl/bank_reg_map_chk.sv
// Protocol checker for bank_reg_map, observing only its ports.
module bank_reg_map_chk
    import bank_reg_map_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] acc_mode,
    input logic [7:0] acc_addr,
    input logic       wr_en,
    input logic [7:0] wr_data,
    input logic [7:0] rd_data,
    input logic [2:0] tgt_kind,
    input logic [7:0] phys_addr,
    input logic [7:0] rp_value,
    input logic       win_d_sel,
    input logic       win_f_sel,
    input logic [3:0] win_idx,
    input logic       win_we
);

    p_ptr_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && tgt_kind == 3'(TK_PTR)) |=> (rp_value == $past(wr_data)));

    p_ptr_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && tgt_kind == 3'(TK_PTR)) |=> $stable(rp_value));

    p_work_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_mode == 2'b01) |-> (phys_addr == {rp_value[7:4], acc_addr[3:0]}));

    p_shadow_direct_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_mode == 2'b00 && acc_addr[7:4] == 4'hE) |-> (tgt_kind == 3'(TK_NONE)));

    p_bad_bank_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_mode != 2'b01 && acc_addr[7:4] == 4'h0 && rp_value[3:0] != 4'h0
         && rp_value[3:0] != 4'hD && rp_value[3:0] != 4'hF)
        |-> (tgt_kind == 3'(TK_NONE)));

    p_none_reads_ones_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_kind == 3'(TK_NONE)) |-> (rd_data == 8'hFF));

    p_one_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({win_d_sel, win_f_sel}));

    p_win_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
        win_we |-> (wr_en && (win_d_sel || win_f_sel)));

    p_win_index_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (win_d_sel || win_f_sel) |-> (win_idx == phys_addr[3:0] && phys_addr[7:4] == 4'h0));

endmodule

bind bank_reg_map bank_reg_map_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_mode  (acc_mode),
    .acc_addr  (acc_addr),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .rd_data   (rd_data),
    .tgt_kind  (tgt_kind),
    .phys_addr (phys_addr),
    .rp_value  (rp_value),
    .win_d_sel (win_d_sel),
    .win_f_sel (win_f_sel),
    .win_idx   (win_idx),
    .win_we    (win_we)
);

// File: tb/sim_bank_reg_map.sv
`timescale 1ns/1ps
// Bench for bank_reg_map: a behavioural model tracks RAM and pointer
// and every access is compared field by field before the clock edge.
module sim_bank_reg_map;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] acc_mode = 2'b00;
    logic [7:0] acc_addr = 8'h00;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic [2:0] tgt_kind;
    logic [7:0] phys_addr;
    logic [7:0] rp_value;
    logic       win_d_sel;
    logic       win_f_sel;
    logic [3:0] win_idx;
    logic       win_we;
    logic [7:0] win_d_rdata;
    logic [7:0] win_f_rdata;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    int model_mem [256];
    int model_rp = 0;

    always #10 clk = ~clk;

    // Windows answer with a pattern derived from the index.
    assign win_d_rdata = {4'hD, win_idx};
    assign win_f_rdata = {4'h3, ~win_idx};

    bank_reg_map u0 (
        .clk(clk), .rst_n(rst_n), .acc_mode(acc_mode), .acc_addr(acc_addr),
        .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .tgt_kind(tgt_kind),
        .phys_addr(phys_addr), .rp_value(rp_value), .win_d_sel(win_d_sel),
        .win_f_sel(win_f_sel), .win_idx(win_idx), .win_we(win_we),
        .win_d_rdata(win_d_rdata), .win_f_rdata(win_f_rdata)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // One access: drive at the falling edge, compare mid-cycle, update model at the rising edge.
    task automatic access(input int mode, input int addr, input bit we, input int wd, input string req);
        int eff, kind, exp_rd, bank;
        @(negedge clk);
        acc_mode = mode[1:0];
        acc_addr = addr[7:0];
        wr_en    = we;
        wr_data  = wd[7:0];
        eff  = (mode == 1) ? ((model_rp / 16) * 16 + (addr % 16)) : addr;
        bank = model_rp % 16;
        if (mode == 0 && eff >= 'hE0 && eff <= 'hEF)      kind = 4;
        else if (eff == 'hFD)                             kind = 3;
        else if (eff >= 'hF0 && eff <= 'hF5)              kind = 4;
        else if (eff < 16 && bank == 0)                   kind = 0;
        else if (eff < 16 && bank == 13)                  kind = 1;
        else if (eff < 16 && bank == 15)                  kind = 2;
        else if (eff < 16)                                kind = 4;
        else                                              kind = 0;
        case (kind)
            0: exp_rd = model_mem[eff];
            1: exp_rd = 'hD0 + (eff % 16);
            2: exp_rd = 'h30 + (15 - eff % 16);
            3: exp_rd = model_rp;
            default: exp_rd = 'hFF;
        endcase
        #5;
        check(req, "rd_data", int'(rd_data), exp_rd);
        check("R12", "tgt_kind", int'(tgt_kind), kind);
        check("R3", "phys_addr", int'(phys_addr), eff);
        check(req, "win_d_sel", int'(win_d_sel), int'(kind == 1));
        check(req, "win_f_sel", int'(win_f_sel), int'(kind == 2));
        check(req, "win_we", int'(win_we), int'(we && (kind == 1 || kind == 2)));
        if (kind == 1 || kind == 2) check(req, "win_idx", int'(win_idx), eff % 16);
        @(posedge clk);
        if (we && kind == 0) model_mem[eff] = wd % 256;
        if (we && kind == 3) model_rp = wd % 256;
        #1;
        check("R10", "rp_value", int'(rp_value), model_rp);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) model_mem[i] = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1: reset state
        check("R1", "rp after reset", int'(rp_value), 0);
        access(0, 'h40, 0, 0, "R1");
        access(2, 'hE7, 0, 0, "R1");
        // R11 / R3: direct writes then reads back
        for (int a = 'h20; a < 'h30; a++) access(0, a, 1, a ^ 'h5A, "R11");
        for (int a = 'h20; a < 'h30; a++) access(0, a, 0, 0, "R11");
        access(3, 'h2C, 0, 0, "R3");
        // R10 / R2: pointer to group 2, working access ignores upper bits
        access(0, 'hFD, 1, 'h20, "R10");
        access(1, 'hA5, 0, 0, "R2");
        access(1, 'h07, 1, 'hC3, "R2");
        access(0, 'h27, 0, 0, "R2");
        // R4: bank 0 low range is RAM
        access(0, 'hFD, 1, 'h00, "R10");
        access(0, 'h07, 1, 'h11, "R4");
        access(0, 'h07, 0, 0, "R4");
        access(1, 'h0E, 1, 'h22, "R4");
        // R5: bank D window
        access(0, 'hFD, 1, 'h0D, "R10");
        access(0, 'h03, 0, 0, "R5");
        access(0, 'h07, 1, 'h99, "R5");
        access(1, 'h0A, 1, 'h55, "R5");
        // R6: bank F window
        access(2, 'hFD, 1, 'h0F, "R10");
        access(0, 'h0C, 0, 0, "R6");
        access(2, 'h07, 1, 'h66, "R6");
        // R7: every unimplemented bank, then RAM unchanged
        for (int b = 1; b < 15; b++) begin
            if (b != 13) begin
                access(0, 'hFD, 1, b, "R10");
                access(0, 'h07, 1, 'h77, "R7");
                access(0, b, 0, 0, "R7");
            end
        end
        access(0, 'hFD, 1, 'h00, "R10");
        access(0, 'h07, 0, 0, "R7");
        access(0, 'h0E, 0, 0, "R7");
        // R8: shadow range E0h-EFh
        access(2, 'hE3, 1, 'h3C, "R8");
        access(0, 'hE3, 0, 0, "R8");
        access(0, 'hE3, 1, 'h99, "R8");
        access(3, 'hE3, 0, 0, "R8");
        access(0, 'hFD, 1, 'hE0, "R10");
        access(1, 'h03, 0, 0, "R8");
        access(1, 'h09, 1, 'h81, "R8");
        access(2, 'hE9, 0, 0, "R8");
        // R9: reserved F0h-F5h, ordinary control bytes F6h-FFh
        for (int a = 'hF0; a < 'hF6; a++) access(2, a, 1, 'h12, "R9");
        for (int a = 'hF0; a < 'hF6; a++) access(0, a, 0, 0, "R9");
        access(0, 'hF8, 1, 'h4B, "R11");
        access(0, 'hF8, 0, 0, "R11");
        // R10: pointer written through a working address in group F
        access(0, 'hFD, 1, 'hF0, "R10");
        access(1, 'h0D, 0, 0, "R10");
        access(1, 'h0D, 1, 'h2D, "R10");
        access(1, 'h07, 0, 0, "R10");
        access(0, 'h05, 0, 0, "R10");
        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule